// File: doc/BRIEF.md
# Carry-Overflow Integer Add/Subtract Unit

This block performs a family of fixed-point additions and subtractions on two operands. It keeps a three-bit exception state: a carry flag, an overflow flag and a sticky summary-overflow flag. Extended operations take the stored carry as their carry-in. The subtract forms compute the second operand minus the first, as B + ~A + carry-in. Every operation maps onto one adder with a carry into the top bit. The carry flag is the adder's carry-out. The overflow flag is the XOR of the carries into and out of the sign bit.

An operation is presented with `op_valid`. Its result and flags are registered at that clock edge, so they appear one cycle later and hold until the next valid operation. Two enables choose whether the operation updates the overflow pair, the carry flag, or both. A separate input clears the sticky summary flag.

Top module: `carry_arith_unit`

## Requirements
- R1: After synchronous reset `res_q` is zero and `ca_q`, `ov_q` and `so_q` are all 0.
- R2: `op_code` 0 (plain add) yields A + B, and its carry-out is 1 exactly when the unsigned result is below A. Codes 9 to 15 behave as code 0.
- R3: For an operation with `ov_en` high, signed overflow sets both `ov_q` and `so_q`. Overflow means the two adder operands share a sign bit and the result's sign bit differs from it.
- R4: For an operation with `ov_en` high and no overflow, `ov_q` becomes 0 and `so_q` keeps its value.
- R5: `op_code` 1 (extended add) yields A + B + CA. Its carry-out is 1 when the result is below A, or when CA was 1 and the result equals A.
- R6: `op_code` 4 (subtract-from) yields B + ~A + 1, and its carry-out is 1 when B ≥ A unsigned. `op_code` 5 (extended subtract-from) yields B + ~A + CA, and its carry-out is 0 only when the result is ≥ B and either CA was 0 or the result differs from B.
- R7: `op_code` 2 yields A + CA − 1. Code 3 yields A + CA. Code 6 yields ~A + CA − 1. Code 7 yields ~A + CA. For each, the carry-out is the carry out of that sum.
- R8: `op_code` 8 (negate) yields −A and computes ~A + 1. It overflows only when A is 0x80000000, and the result is then 0x80000000.
- R9: With `ca_en` low a valid operation leaves `ca_q` unchanged. With `ov_en` low it leaves `ov_q` and `so_q` unchanged.
- R10: While `op_valid` is low, `res_q`, `ca_q` and `ov_q` hold their values.
- R11: `so_clear` clears `so_q` at the next edge. When an overflowing operation with `ov_en` high happens in the same cycle, `so_q` is set instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation select |
| opnd_a | input | WIDTH | Operand A |
| opnd_b | input | WIDTH | Operand B |
| ov_en | input | 1 | Operation updates overflow and summary flags |
| ca_en | input | 1 | Operation updates carry flag |
| so_clear | input | 1 | Clear summary overflow |
| res_q | output | WIDTH | Registered result |
| ca_q | output | 1 | Carry flag |
| ov_q | output | 1 | Overflow flag |
| so_q | output | 1 | Sticky summary overflow flag |

## Verification
The properties assume that `op_code`, the enables and `so_clear` are known (never X) whenever they are sampled. They also assume a clear that does not coincide with an overflowing operation is meant to drop the summary flag. The stimulus drives every input at the falling edge with defined values. It uses the unused opcodes only as explicit aliases of the plain add. It asserts `so_clear` both alone and together with an overflowing add, so both sides of the priority rule stay within what the checker expects.

// File: rtl/cau_pkg.sv
package cau_pkg;

   typedef enum logic [3:0] {
      OPC_ADD   = 4'd0,
      OPC_ADDX  = 4'd1,
      OPC_ADDM  = 4'd2,
      OPC_ADDZ  = 4'd3,
      OPC_SUBF  = 4'd4,
      OPC_SUBFX = 4'd5,
      OPC_SUBFM = 4'd6,
      OPC_SUBFZ = 4'd7,
      OPC_NEG   = 4'd8
   } cau_op_e;

   typedef struct packed {
      logic ca;
      logic ov;
      logic so;
   } cau_flags_t;

endpackage

// File: rtl/cau_operand_sel.sv
module cau_operand_sel
   import cau_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [3:0]       op_code,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic             ca_in,
   output logic [WIDTH-1:0] add_x,
   output logic [WIDTH-1:0] add_y,
   output logic             add_cin
);

   localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] ALL_ZERO = {WIDTH{1'b0}};

   cau_op_e op;
   assign op = cau_op_e'(op_code);

   always_comb begin
      add_x   = opnd_a;
      add_y   = opnd_b;
      add_cin = 1'b0;
      unique case (op)
         OPC_ADDX: begin
            add_cin = ca_in;
         end
         OPC_ADDM: begin
            add_y   = ALL_ONES;
            add_cin = ca_in;
         end
         OPC_ADDZ: begin
            add_y   = ALL_ZERO;
            add_cin = ca_in;
         end
         OPC_SUBF: begin
            add_x   = ~opnd_a;
            add_cin = 1'b1;
         end
         OPC_SUBFX: begin
            add_x   = ~opnd_a;
            add_cin = ca_in;
         end
         OPC_SUBFM: begin
            add_x   = ~opnd_a;
            add_y   = ALL_ONES;
            add_cin = ca_in;
         end
         OPC_SUBFZ: begin
            add_x   = ~opnd_a;
            add_y   = ALL_ZERO;
            add_cin = ca_in;
         end
         OPC_NEG: begin
            add_x   = ~opnd_a;
            add_y   = ALL_ZERO;
            add_cin = 1'b1;
         end
         default: begin
            add_x   = opnd_a;
            add_y   = opnd_b;
            add_cin = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/cau_adder.sv
module cau_adder #(
   parameter int WIDTH      = 32,
   parameter bit USE_RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] add_x,
   input  logic [WIDTH-1:0] add_y,
   input  logic             add_cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);

   localparam int MSB = WIDTH - 1;

   if (USE_RIPPLE) begin : g_ripple
      logic [WIDTH:0] carry;
      assign carry[0] = add_cin;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign sum[i]     = add_x[i] ^ add_y[i] ^ carry[i];
         assign carry[i+1] = (add_x[i] & add_y[i]) | (carry[i] & (add_x[i] ^ add_y[i]));
      end
      assign cout = carry[WIDTH];
      assign ovf  = carry[WIDTH] ^ carry[MSB];
   end else begin : g_fast
      logic [WIDTH:0] full;
      logic           c_into_msb;
      assign full       = {1'b0, add_x} + {1'b0, add_y} + {{WIDTH{1'b0}}, add_cin};
      assign sum        = full[MSB:0];
      assign cout       = full[WIDTH];
      assign c_into_msb = add_x[MSB] ^ add_y[MSB] ^ full[MSB];
      assign ovf        = cout ^ c_into_msb;
   end

endmodule

// File: rtl/cau_flag_ctl.sv
module cau_flag_ctl
   import cau_pkg::*;
(
   input  cau_flags_t cur,
   input  logic       op_valid,
   input  logic       ov_en,
   input  logic       ca_en,
   input  logic       so_clear,
   input  logic       cout,
   input  logic       ovf,
   output cau_flags_t nxt
);

   logic take_ov;
   logic take_ca;

   assign take_ov = op_valid & ov_en;
   assign take_ca = op_valid & ca_en;

   always_comb begin
      nxt.ca = take_ca ? cout : cur.ca;
      nxt.ov = take_ov ? ovf  : cur.ov;
      nxt.so = (cur.so & ~so_clear) | (take_ov & ovf);
   end

endmodule

// File: rtl/carry_arith_unit.sv
module carry_arith_unit
   import cau_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter bit USE_RIPPLE = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             op_valid,
   input  logic [3:0]       op_code,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic             ov_en,
   input  logic             ca_en,
   input  logic             so_clear,
   output logic [WIDTH-1:0] res_q,
   output logic             ca_q,
   output logic             ov_q,
   output logic             so_q
);

   if (WIDTH < 2) begin : g_width_check
      $error("carry_arith_unit: WIDTH must be at least 2");
   end

   cau_flags_t       flags_q;
   cau_flags_t       flags_d;
   logic [WIDTH-1:0] add_x;
   logic [WIDTH-1:0] add_y;
   logic             add_cin;
   logic [WIDTH-1:0] sum;
   logic             cout;
   logic             ovf;

   cau_operand_sel #(.WIDTH(WIDTH)) u_sel (
      .op_code (op_code),
      .opnd_a  (opnd_a),
      .opnd_b  (opnd_b),
      .ca_in   (flags_q.ca),
      .add_x   (add_x),
      .add_y   (add_y),
      .add_cin (add_cin)
   );

   cau_adder #(.WIDTH(WIDTH), .USE_RIPPLE(USE_RIPPLE)) u_add (
      .add_x   (add_x),
      .add_y   (add_y),
      .add_cin (add_cin),
      .sum     (sum),
      .cout    (cout),
      .ovf     (ovf)
   );

   cau_flag_ctl u_flags (
      .cur      (flags_q),
      .op_valid (op_valid),
      .ov_en    (ov_en),
      .ca_en    (ca_en),
      .so_clear (so_clear),
      .cout     (cout),
      .ovf      (ovf),
      .nxt      (flags_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         res_q   <= '0;
         flags_q <= '0;
      end else begin
         flags_q <= flags_d;
         if (op_valid) begin
            res_q <= sum;
         end
      end
   end

   assign ca_q = flags_q.ca;
   assign ov_q = flags_q.ov;
   assign so_q = flags_q.so;

endmodule

// File: rtl/carry_arith_unit_chk.sv
module carry_arith_unit_chk
   import cau_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst,
   input logic             op_valid,
   input logic [3:0]       op_code,
   input logic [WIDTH-1:0] opnd_a,
   input logic [WIDTH-1:0] opnd_b,
   input logic             ov_en,
   input logic             ca_en,
   input logic             so_clear,
   input logic [WIDTH-1:0] res_q,
   input logic             ca_q,
   input logic             ov_q,
   input logic             so_q
);

   localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

   // R3
   ov_implies_so_chk: assert property (@(posedge clk) disable iff (rst)
      (op_valid && ov_en) |=> (!ov_q || so_q));

   // R4
   so_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (so_q && !so_clear) |=> so_q);

   // R11
   so_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (so_clear && !(op_valid && ov_en)) |=> !so_q);

   // R9
   ca_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (op_valid && !ca_en) |=> $stable(ca_q));

   // R9
   ov_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (op_valid && !ov_en) |=> $stable(ov_q));

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      !op_valid |=> ($stable(res_q) && $stable(ca_q) && $stable(ov_q)));

   // R8
   neg_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      (op_valid && ov_en && op_code == OPC_NEG && opnd_a != MOST_NEG) |=> !ov_q);

   // R8
   neg_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      (op_valid && ov_en && op_code == OPC_NEG && opnd_a == MOST_NEG) |=> (ov_q && so_q && res_q == MOST_NEG));

endmodule

bind carry_arith_unit carry_arith_unit_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/carry_arith_unit_bench.sv
module carry_arith_unit_bench;

   typedef struct {
      logic [31:0] r;
      logic        ca;
      logic        ov;
      logic        so;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        op_valid = 1'b0;
   logic [3:0]  op_code = 4'd0;
   logic [31:0] opnd_a = '0;
   logic [31:0] opnd_b = '0;
   logic        ov_en = 1'b0;
   logic        ca_en = 1'b0;
   logic        so_clear = 1'b0;
   logic [31:0] res_q;
   logic        ca_q, ov_q, so_q;

   int   n_checks = 0;
   int   n_fail   = 0;
   bit   done     = 1'b0;
   exp_t sb_q[$];

   logic [31:0] m_res = '0;
   logic        m_ca = 1'b0, m_ov = 1'b0, m_so = 1'b0;

   always #5 clk = ~clk;

   carry_arith_unit u_carry_arith_unit (
      .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .ov_en(ov_en), .ca_en(ca_en),
      .so_clear(so_clear), .res_q(res_q), .ca_q(ca_q), .ov_q(ov_q), .so_q(so_q)
   );

   // Reference model written from the relational rules of the requirements.
   function automatic void model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                                 input logic cin, output logic [31:0] r, output logic c, output logic o);
      logic [31:0] na;
      na = ~a;
      case (op)
         4'd1: begin // R5
            r = a + b + {31'd0, cin};
            c = (r < a) || (cin && r == a);
            o = (a[31] == b[31]) && (r[31] != a[31]);
         end
         4'd2: begin // R7
            r = a + {31'd0, cin} - 32'd1;
            c = cin || (a != 32'd0);
            o = a[31] && !r[31];
         end
         4'd3: begin // R7
            r = a + {31'd0, cin};
            c = r < a;
            o = !a[31] && r[31];
         end
         4'd4: begin // R6
            r = b - a;
            c = b >= a;
            o = (na[31] == b[31]) && (r[31] != b[31]);
         end
         4'd5: begin // R6
            r = b + na + {31'd0, cin};
            c = !((r >= b) && (!cin || r != b));
            o = (na[31] == b[31]) && (r[31] != b[31]);
         end
         4'd6: begin // R7
            r = na + {31'd0, cin} - 32'd1;
            c = cin || (na != 32'd0);
            o = na[31] && !r[31];
         end
         4'd7: begin // R7
            r = na + {31'd0, cin};
            c = r < na;
            o = !na[31] && r[31];
         end
         4'd8: begin // R8
            r = 32'd0 - a;
            c = (a == 32'd0);
            o = (a == 32'h8000_0000);
         end
         default: begin // R2
            r = a + b;
            c = r < a;
            o = (a[31] == b[31]) && (r[31] != a[31]);
         end
      endcase
   endfunction

   task automatic step(input logic v, input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic uov, input logic uca, input logic clr, input string tag);
      logic [31:0] r;
      logic        c, o;
      exp_t        it;
      @(negedge clk);
      op_valid = v; op_code = op; opnd_a = a; opnd_b = b;
      ov_en = uov; ca_en = uca; so_clear = clr;
      model(op, a, b, m_ca, r, c, o);
      m_so = m_so & ~clr;
      if (v) begin
         m_res = r;
         if (uca) m_ca = c;
         if (uov) begin
            m_ov = o;
            m_so = m_so | o;
         end
      end
      @(posedge clk);
      #1;
      it.r = m_res; it.ca = m_ca; it.ov = m_ov; it.so = m_so; it.tag = tag;
      sb_q.push_back(it);
   endtask

   // Monitor: compares outputs against the queue head away from the active edge.
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t it;
         it = sb_q.pop_front();
         n_checks++;
         if (res_q !== it.r || ca_q !== it.ca || ov_q !== it.ov || so_q !== it.so) begin
            n_fail++;
            $display("FAIL %s: got res=%h ca=%b ov=%b so=%b expected res=%h ca=%b ov=%b so=%b",
                     it.tag, res_q, ca_q, ov_q, so_q, it.r, it.ca, it.ov, it.so);
         end
      end
   end

   function automatic logic [31:0] pick_opnd();
      case ($urandom_range(0, 6))
         0: return 32'h0000_0000;
         1: return 32'h0000_0001;
         2: return 32'h7FFF_FFFF;
         3: return 32'h8000_0000;
         4: return 32'hFFFF_FFFF;
         default: return $urandom();
      endcase
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      n_checks++;
      if (res_q !== 32'd0 || ca_q !== 1'b0 || ov_q !== 1'b0 || so_q !== 1'b0) begin
         n_fail++;
         $display("FAIL R1: got res=%h ca=%b ov=%b so=%b expected res=0 ca=0 ov=0 so=0",
                  res_q, ca_q, ov_q, so_q);
      end
      step(1, 4'd0, 32'h7FFF_FFFF, 32'h0000_0001, 1, 1, 0, "R3");
      step(1, 4'd0, 32'hFFFF_FFFF, 32'h0000_0001, 1, 1, 0, "R2");
      step(1, 4'd0, 32'h0000_0010, 32'h0000_0020, 1, 1, 0, "R4");
      step(0, 4'd0, 32'h1234_5678, 32'h1111_1111, 1, 1, 1, "R11");
      step(1, 4'd0, 32'h8000_0000, 32'h8000_0000, 1, 1, 1, "R11");
      step(1, 4'd0, 32'hFFFF_FFFF, 32'h0000_0002, 0, 1, 0, "R2");
      step(1, 4'd1, 32'h0000_0005, 32'hFFFF_FFFF, 1, 1, 0, "R5");
      step(1, 4'd1, 32'h0000_0005, 32'h0000_0003, 1, 1, 0, "R5");
      step(1, 4'd4, 32'h0000_0003, 32'h0000_000A, 1, 1, 0, "R6");
      step(1, 4'd4, 32'h0000_000A, 32'h0000_0003, 1, 1, 0, "R6");
      step(1, 4'd5, 32'h0000_0000, 32'h0000_0009, 1, 1, 0, "R6");
      step(1, 4'd5, 32'hFFFF_FFFF, 32'h0000_0009, 1, 1, 0, "R6");
      step(1, 4'd2, 32'h0000_0000, 32'h0, 1, 1, 0, "R7");
      step(1, 4'd3, 32'hFFFF_FFFF, 32'h0, 1, 1, 0, "R7");
      step(1, 4'd3, 32'h7FFF_FFFF, 32'h0, 1, 1, 0, "R7");
      step(1, 4'd6, 32'hFFFF_FFFF, 32'h0, 1, 1, 0, "R7");
      step(1, 4'd7, 32'h0000_0000, 32'h0, 1, 1, 0, "R7");
      step(1, 4'd8, 32'h8000_0000, 32'h0, 1, 1, 1, "R8");
      step(1, 4'd8, 32'h0000_0005, 32'h0, 1, 1, 0, "R8");
      step(1, 4'd8, 32'h0000_0000, 32'h0, 1, 1, 0, "R8");
      step(1, 4'd0, 32'hFFFF_FFFF, 32'h0000_0001, 1, 0, 0, "R9");
      step(1, 4'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 1, 0, "R9");
      step(0, 4'd4, 32'hDEAD_BEEF, 32'h0BAD_F00D, 1, 1, 0, "R10");
      step(1, 4'd12, 32'h4000_0000, 32'h4000_0000, 1, 1, 0, "R2");
      for (int i = 0; i < 400; i++) begin
         step($urandom_range(0, 7) != 0, 4'($urandom_range(0, 10)), pick_opnd(), pick_opnd(),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom_range(0, 5) == 0, "R3");
      end
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

endmodule